// File: doc/BRIEF.md
# Two-Channel Serial Interrupt Status Unit

This unit holds the receive and transmit interrupt state of a serial controller with two channels, A and B. Each channel reports a few events: a byte arrived, software read the data register, software wrote transmit data, or software wrote a command to the control register. From these events the unit keeps two status bytes per channel: a buffer status byte and a transmit status byte. It also keeps one interrupt-pending byte that is read through channel A and carries the flags of both channels at fixed bit positions.

A single interrupt line is the OR of the four flags, gated by a master enable. The line follows the flags with no added delay, so it changes in the same cycle as the pending byte. Status reads do not disturb any state. They are plain views of the registers, which the surrounding register file can mux out.

Top module: `serIntStatus`

## Requirements
- R1: After reset the pending byte is 0x00, each channel's buffer status byte is 0x04 (only bit 2, buffer empty, set), each transmit status byte is 0x00, and the interrupt line is low.
- R2: A byte-received pulse on a channel sets bit 0 of that channel's buffer status byte and its receive pending bit, one clock later. The receive pending bit is bit 5 for channel A and bit 2 for channel B.
- R3: A transmit-write pulse on a channel sets bit 2 of its buffer status byte, bit 0 of its transmit status byte, and its transmit pending bit, one clock later. The transmit pending bit is bit 4 for channel A and bit 1 for channel B.
- R4: A data-register read pulse clears bit 0 of that channel's buffer status byte and its receive pending bit, one clock later. The transmit pending bit is left as it is.
- R5: Command byte 0x20 clears only that channel's receive pending bit. Bit 0 of the buffer status byte is kept.
- R6: Command byte 0x28 clears only that channel's transmit pending bit. The status bytes are kept.
- R7: Command byte 0x38 clears both pending bits of that channel.
- R8: Any other command byte changes no status or pending bit.
- R9: The interrupt line is high exactly when the master enable is high and at least one of the four pending flags is set. It follows a change of the enable within the same cycle.
- R10: When a channel gets a set event and a clear event for the same flag in the same clock, the set wins.
- R11: Events on one channel never change the other channel's status bytes or pending bits.
- R12: Pending bits 7, 6, 3 and 0 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxByte | input | 2 | Byte received pulse, bit 0 = channel A, bit 1 = channel B |
| dataRd | input | 2 | Data register read pulse, per channel |
| txWr | input | 2 | Transmit data write pulse, per channel |
| cmdWr | input | 2 | Command register write strobe, per channel |
| cmdData | input | 16 | Command bytes, [7:0] channel A, [15:8] channel B |
| masterIe | input | 1 | Master interrupt enable |
| bufStat | output | 16 | Buffer status bytes, [7:0] channel A, [15:8] channel B |
| txStat | output | 16 | Transmit status bytes, [7:0] channel A, [15:8] channel B |
| pendStat | output | 8 | Shared interrupt pending byte |
| irq | output | 1 | Interrupt request |

## Verification
Every event is registered once, so status and pending bits are due at the first rising edge after the pulse. The interrupt line is combinational from the flags, so it moves in that same cycle; a change of the enable alone moves it without any edge. The bench drives every pulse on a falling edge and samples on the next falling edge, which places the result exactly one edge after the stimulus. For checks on the enable alone, it samples a short delay after the change with no edge in between.

// File: rtl/serIntPkg.sv
package serIntPkg;
  localparam int NUM_CH = 2;
  localparam int REG_W  = 8;
  localparam int CMD_W  = 8;

  localparam logic [CMD_W-1:0] CMD_CLR_RX   = 8'h20;
  localparam logic [CMD_W-1:0] CMD_CLR_TX   = 8'h28;
  localparam logic [CMD_W-1:0] CMD_CLR_BOTH = 8'h38;

  localparam int AVAIL_BIT = 0;
  localparam int EMPTY_BIT = 2;
  localparam int SENT_BIT  = 0;

  typedef struct packed {
    logic setRx;
    logic clrRx;
    logic setTx;
    logic clrTx;
    logic clrAvail;
  } chStrobe_t;

  function automatic int rxPendBit(input int ch);
    return (ch == 0) ? 5 : 2;
  endfunction

  function automatic int txPendBit(input int ch);
    return (ch == 0) ? 4 : 1;
  endfunction
endpackage

// File: rtl/serIntCtrl.sv
module serIntCtrl
  import serIntPkg::*;
(
  input  logic [NUM_CH-1:0]       rxByte,
  input  logic [NUM_CH-1:0]       dataRd,
  input  logic [NUM_CH-1:0]       txWr,
  input  logic [NUM_CH-1:0]       cmdWr,
  input  logic [NUM_CH*CMD_W-1:0] cmdData,
  output chStrobe_t [NUM_CH-1:0]  strb
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [CMD_W-1:0] code;
    logic cmdRx, cmdTx;
    assign code  = cmdData[c*CMD_W +: CMD_W];
    assign cmdRx = cmdWr[c] && (code == CMD_CLR_RX || code == CMD_CLR_BOTH);
    assign cmdTx = cmdWr[c] && (code == CMD_CLR_TX || code == CMD_CLR_BOTH);
    always_comb begin
      strb[c].setRx    = rxByte[c];
      strb[c].clrRx    = dataRd[c] || cmdRx;
      strb[c].setTx    = txWr[c];
      strb[c].clrTx    = cmdTx;
      strb[c].clrAvail = dataRd[c];
    end
  end
endmodule

// File: rtl/serIntData.sv
module serIntData
  import serIntPkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  chStrobe_t [NUM_CH-1:0]  strb,
  input  logic                    masterIe,
  output logic [NUM_CH*REG_W-1:0] bufStat,
  output logic [NUM_CH*REG_W-1:0] txStat,
  output logic [REG_W-1:0]        pendStat,
  output logic                    irq
);
  localparam logic [REG_W-1:0] BUF_RST = REG_W'(1) << EMPTY_BIT;

  logic [NUM_CH-1:0] rxFlag, txFlag;
  logic [REG_W-1:0]  pendPart [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [REG_W-1:0] bufReg, txReg;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        bufReg    <= BUF_RST;
        txReg     <= '0;
        rxFlag[c] <= 1'b0;
        txFlag[c] <= 1'b0;
      end else begin
        if (strb[c].setRx)      rxFlag[c] <= 1'b1;
        else if (strb[c].clrRx) rxFlag[c] <= 1'b0;
        if (strb[c].setTx)      txFlag[c] <= 1'b1;
        else if (strb[c].clrTx) txFlag[c] <= 1'b0;
        if (strb[c].setRx)         bufReg[AVAIL_BIT] <= 1'b1;
        else if (strb[c].clrAvail) bufReg[AVAIL_BIT] <= 1'b0;
        if (strb[c].setTx) begin
          bufReg[EMPTY_BIT] <= 1'b1;
          txReg[SENT_BIT]   <= 1'b1;
        end
      end
    end
    assign bufStat[c*REG_W +: REG_W] = bufReg;
    assign txStat[c*REG_W +: REG_W]  = txReg;
    always_comb begin
      pendPart[c] = '0;
      pendPart[c][rxPendBit(c)] = rxFlag[c];
      pendPart[c][txPendBit(c)] = txFlag[c];
    end
  end

  always_comb begin
    pendStat = '0;
    for (int c = 0; c < NUM_CH; c++) pendStat |= pendPart[c];
  end

  assign irq = masterIe && (|rxFlag || |txFlag);
endmodule

// File: rtl/serIntStatus.sv
module serIntStatus
  import serIntPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  rxByte,
  input  logic [1:0]  dataRd,
  input  logic [1:0]  txWr,
  input  logic [1:0]  cmdWr,
  input  logic [15:0] cmdData,
  input  logic        masterIe,
  output logic [15:0] bufStat,
  output logic [15:0] txStat,
  output logic [7:0]  pendStat,
  output logic        irq
);
  chStrobe_t [NUM_CH-1:0] strb;

  serIntCtrl u_ctrl (
    .rxByte (rxByte),
    .dataRd (dataRd),
    .txWr   (txWr),
    .cmdWr  (cmdWr),
    .cmdData(cmdData),
    .strb   (strb)
  );

  serIntData u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .masterIe(masterIe),
    .bufStat (bufStat),
    .txStat  (txStat),
    .pendStat(pendStat),
    .irq     (irq)
  );
endmodule

// File: rtl/serIntStatusChk.sv
module serIntStatusChk (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  rxByte,
  input logic [1:0]  dataRd,
  input logic [1:0]  txWr,
  input logic [1:0]  cmdWr,
  input logic [15:0] cmdData,
  input logic        masterIe,
  input logic [15:0] bufStat,
  input logic [15:0] txStat,
  input logic [7:0]  pendStat,
  input logic        irq
);
  AST_RX_A_SETS: assert property (@(posedge clk) disable iff (!rstN)
    rxByte[0] |=> pendStat[5] && bufStat[0]); // R2
  AST_RX_B_SETS: assert property (@(posedge clk) disable iff (!rstN)
    rxByte[1] |=> pendStat[2] && bufStat[8]); // R2
  AST_TX_A_SETS: assert property (@(posedge clk) disable iff (!rstN)
    txWr[0] |=> pendStat[4] && bufStat[2] && txStat[0]); // R3
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd[0] && !rxByte[0]) |=> !pendStat[5] && !bufStat[0]); // R4
  AST_CMD_BOTH_A: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr[0] && cmdData[7:0] == 8'h38 && !rxByte[0] && !txWr[0])
      |=> !pendStat[5] && !pendStat[4]); // R7
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !masterIe |-> !irq); // R9
  AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rstN)
    (masterIe && pendStat != 8'h00) |-> irq); // R9
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    pendStat[7:6] == 2'b00 && !pendStat[3] && !pendStat[0]); // R12
  AST_B_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (rxByte[1] == 1'b0 && dataRd[1] == 1'b0 && txWr[1] == 1'b0 && cmdWr[1] == 1'b0)
      |=> $stable(bufStat[15:8]) && $stable(txStat[15:8])); // R11
endmodule

bind serIntStatus serIntStatusChk u_chk (.*);

// File: tb/serIntStatus_tb.sv
module serIntStatus_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  rxByte, dataRd, txWr, cmdWr;
  logic [15:0] cmdData;
  logic        masterIe;
  logic [15:0] bufStat, txStat;
  logic [7:0]  pendStat;
  logic        irq;
  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serIntStatus u_dut (.*);

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic int rxP(input int ch); return ch == 0 ? 5 : 2; endfunction
  function automatic int txP(input int ch); return ch == 0 ? 4 : 1; endfunction

  task automatic idle();
    rxByte = '0; dataRd = '0; txWr = '0; cmdWr = '0; cmdData = '0;
  endtask

  task automatic doReset();
    @(negedge clk);
    idle(); masterIe = 1'b1; rstN = 1'b0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic sendCmd(input int ch, input logic [7:0] code);
    @(negedge clk);
    cmdWr[ch] = 1'b1; cmdData[ch*8 +: 8] = code;
    step();
  endtask

  task automatic t_reset();
    doReset();
    check("R1 pend", pendStat, 8'h00);
    check("R1 buf", bufStat, 16'h0404);
    check("R1 tx", txStat, 16'h0000);
    check("R1 irq", irq, 1'b0);
  endtask

  task automatic t_rx(input int ch);
    doReset();
    @(negedge clk); rxByte[ch] = 1'b1; step();
    check("R2 pend", pendStat, 8'(1 << rxP(ch)));
    check("R2 buf", bufStat, ch == 0 ? 16'h0405 : 16'h0504);
    check("R11 other tx", txStat, 16'h0000);
    check("R9 irq on rx", irq, 1'b1);
  endtask

  task automatic t_tx(input int ch);
    doReset();
    @(negedge clk); txWr[ch] = 1'b1; step();
    check("R3 pend", pendStat, 8'(1 << txP(ch)));
    check("R3 tx", txStat, ch == 0 ? 16'h0001 : 16'h0100);
    check("R3 buf", bufStat, 16'h0404);
  endtask

  task automatic t_read();
    doReset();
    @(negedge clk); rxByte = 2'b11; txWr = 2'b01; step();
    check("R2 both pend", pendStat, 8'h34);
    @(negedge clk); dataRd[0] = 1'b1; step();
    check("R4 pend", pendStat, 8'h14);
    check("R4 buf", bufStat, 16'h0504);
  endtask

  task automatic t_cmds();
    doReset();
    @(negedge clk); rxByte = 2'b11; txWr = 2'b11; step();
    check("R2R3 all pend", pendStat, 8'h36);
    sendCmd(0, 8'h20);
    check("R5 clr rx A", pendStat, 8'h16);
    check("R5 avail kept", bufStat, 16'h0505);
    sendCmd(1, 8'h28);
    check("R6 clr tx B", pendStat, 8'h14);
    check("R6 tx kept", txStat, 16'h0101);
    sendCmd(0, 8'h30);
    check("R8 other code", pendStat, 8'h14);
    sendCmd(1, 8'h21);
    check("R8 near code", pendStat, 8'h14);
    check("R8 buf kept", bufStat, 16'h0505);
    sendCmd(0, 8'h38);
    check("R7 clr both A", pendStat, 8'h04);
    sendCmd(1, 8'h38);
    check("R7 clr both B", pendStat, 8'h00);
    check("R9 irq idle", irq, 1'b0);
  endtask

  task automatic t_collide();
    doReset();
    @(negedge clk); rxByte[1] = 1'b1; dataRd[1] = 1'b1; step();
    check("R10 rx vs read pend", pendStat, 8'h04);
    check("R10 rx vs read buf", bufStat, 16'h0504);
    @(negedge clk); txWr[0] = 1'b1; cmdWr[0] = 1'b1; cmdData[7:0] = 8'h38; step();
    check("R10 tx vs cmd", pendStat, 8'h14);
  endtask

  task automatic t_enable();
    doReset();
    @(negedge clk); masterIe = 1'b0; txWr[1] = 1'b1; step();
    check("R9 masked", irq, 1'b0);
    check("R3 masked pend", pendStat, 8'h02);
    #1 masterIe = 1'b1;
    #1 check("R9 enable same cycle", irq, 1'b1);
    #1 masterIe = 1'b0;
    #1 check("R9 disable same cycle", irq, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFails++;
    $display("FAIL watchdog all-reqs actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    idle(); masterIe = 1'b1; rstN = 1'b0;
    t_reset();
    t_rx(0); t_rx(1);
    t_tx(0); t_tx(1);
    t_read();
    t_cmds();
    t_collide();
    t_enable();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule